// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the state keeper for a microcontroller's power modes. It holds the current mode and drives the gating and enable lines that put that mode into effect. Those lines cover the CPU clock, the core-domain clock, the high-speed oscillators, the low-speed internal oscillator, the main and low-power regulators, the core-domain power switch, the SRAM supply, the supply monitor and the system-clock source select. Software asks for a mode by placing a code on `mode_sel_i` and pulsing `wfi_i`. Any of the wakeup lines brings the device back out.

Requests are only taken while the core is executing, which means in the run or low-power-run mode. A request that breaks a legality rule leaves the mode as it is and pulses `err_o`. Wakeup from a stop mode goes back to the mode the stop was entered from, with no reset. Wakeup from standby or shutdown first holds a core-domain reset for a fixed number of cycles and then lands in run mode.

Top module: `lpm_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block is in run mode: `mode_o`=0, `err_o`=0, `core_rst_o`=0, `clk_src_o`=0, and every clock, oscillator, main regulator, power, SRAM and monitor enable is 1, with `lp_reg_en_o`=0.
- R2: The mode codes, used both for `mode_sel_i` and `mode_o`, are: 0 run, 1 low-power run, 2 sleep, 3 low-power sleep, 4 stop0, 5 stop1, 6 standby, 7 shutdown. A request for low-power run from run is accepted only when `clk_div_i` >= LP_DIV (4; the clock is 16 MHz shifted right by `clk_div_i`). Otherwise the mode stays run and `err_o` pulses high for one cycle. A request for run from low-power run is always accepted.
- R3: A low-power sleep request is accepted only from low-power run, and a sleep request only from run. A request that breaks either rule leaves the mode unchanged and pulses `err_o` for one cycle.
- R4: `wfi_i` is ignored in every mode except run and low-power run, and during the core-domain reset. Wakeup lines are ignored in run and low-power run, so mode and `clk_src_o` are unchanged.
- R5: Sleep and low-power sleep turn off `cpu_clk_en_o` and keep `core_clk_en_o` on. Low-power sleep uses the low-power regulator. A wakeup returns to run or low-power run, respectively.
- R6: In both stop modes the core clock and the high-speed oscillators are off, while `lsi_en_o`, `sram_on_o` and `core_pwr_en_o` stay on. Stop0 keeps the main regulator on with the low-power regulator off. Stop1 does the opposite.
- R7: A stop request from low-power run is rejected with `err_o` when `clk_div_i` < LP_DIV. Wakeup from a stop mode returns to the mode it was entered from, with `clk_src_o`=0 (divided RC) and no core reset.
- R8: In standby `core_pwr_en_o` is 0 and the main regulator is off. `sram_keep_i`, captured on entry, decides the rest. With it set, `sram_on_o`=1 and `lp_reg_en_o`=1. With it clear, both are 0. Changes to `sram_keep_i` after entry have no effect.
- R9: In shutdown `lsi_en_o`, `vmon_en_o`, `sram_on_o`, `core_pwr_en_o` and both regulator enables are 0.
- R10: Wakeup from standby or shutdown holds `core_rst_o` high for exactly RST_CYC (8) cycles with `mode_o`=0. The block then enters run with `clk_src_o`=1 (undivided 16 MHz RC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 3 | Requested mode code |
| sram_keep_i | input | 1 | Keep SRAM powered in standby |
| clk_div_i | input | DIV_W | Core clock divider setting |
| wfi_i | input | 1 | Mode request strobe |
| wake_i | input | WAKE_W | Wakeup event lines |
| mode_o | output | 3 | Current mode code |
| err_o | output | 1 | One-cycle pulse on a rejected request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| core_clk_en_o | output | 1 | Core-domain clock enable |
| hs_osc_en_o | output | 1 | PLL and high-speed oscillator enable |
| lsi_en_o | output | 1 | Low-speed internal oscillator enable |
| main_reg_en_o | output | 1 | Main regulator enable |
| lp_reg_en_o | output | 1 | Low-power regulator enable |
| core_pwr_en_o | output | 1 | Core-domain power switch |
| sram_on_o | output | 1 | SRAM supply enable |
| vmon_en_o | output | 1 | Supply monitor enable |
| clk_src_o | output | 1 | System clock source: 0 divided RC, 1 undivided 16 MHz RC |
| core_rst_o | output | 1 | Core-domain reset after deep wakeup |

## Verification
All outputs decode directly from the state register, so a wrong state shows up at `mode_o` and in the enable pattern one cycle after the edge that took it. The two exceptions are a lost stop-return flag and a wrong retention capture. These stay hidden until the wakeup or the standby supply pattern exposes them, so they are checked by entering a mode, disturbing the inputs, and then waking. A wrong reset counter shows up as a `core_rst_o` pulse of the wrong length, which is measured cycle by cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_RUN      = 3'd0,
    M_LPRUN    = 3'd1,
    M_SLEEP    = 3'd2,
    M_LPSLEEP  = 3'd3,
    M_STOP0    = 3'd4,
    M_STOP1    = 3'd5,
    M_STANDBY  = 3'd6,
    M_SHUTDOWN = 3'd7
  } mode_e;

  // low codes mirror mode_e; S_WRST is the post-wakeup reset phase
  typedef enum logic [3:0] {
    S_RUN      = 4'd0,
    S_LPRUN    = 4'd1,
    S_SLEEP    = 4'd2,
    S_LPSLEEP  = 4'd3,
    S_STOP0    = 4'd4,
    S_STOP1    = 4'd5,
    S_STANDBY  = 4'd6,
    S_SHUTDOWN = 4'd7,
    S_WRST     = 4'd8
  } state_e;

  typedef enum logic {
    CLK_RC_DIV = 1'b0,
    CLK_RC16   = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic cpu_clk;
    logic core_clk;
    logic hs_osc;
    logic lsi;
    logic main_reg;
    logic lp_reg;
    logic core_pwr;
    logic sram_on;
    logic vmon;
    logic core_rst;
  } pwr_ctl_t;

endpackage

// File: rtl/lpm_req_check.sv
module lpm_req_check
  import lpm_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int LP_DIV = 4
) (
  input  state_e             cur_i,
  input  mode_e              sel_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               accept_o,
  output logic               reject_o,
  output state_e             nxt_o
);

  localparam logic [DIV_W-1:0] LP_DIV_V = DIV_W'(LP_DIV);

  logic slow_clk;
  assign slow_clk = (div_i >= LP_DIV_V);

  always_comb begin
    accept_o = 1'b0;
    reject_o = 1'b0;
    nxt_o    = cur_i;
    unique case (sel_i)
      M_RUN: begin
        if (cur_i == S_LPRUN) begin
          accept_o = 1'b1;
          nxt_o    = S_RUN;
        end
      end
      M_LPRUN: begin
        if (cur_i == S_RUN) begin
          if (slow_clk) begin
            accept_o = 1'b1;
            nxt_o    = S_LPRUN;
          end else begin
            reject_o = 1'b1;
          end
        end
      end
      M_SLEEP: begin
        if (cur_i == S_RUN) begin
          accept_o = 1'b1;
          nxt_o    = S_SLEEP;
        end else begin
          reject_o = 1'b1;
        end
      end
      M_LPSLEEP: begin
        if (cur_i == S_LPRUN) begin
          accept_o = 1'b1;
          nxt_o    = S_LPSLEEP;
        end else begin
          reject_o = 1'b1;
        end
      end
      M_STOP0, M_STOP1: begin
        // wake target low-power run needs the slow clock already set
        if (cur_i == S_LPRUN && !slow_clk) begin
          reject_o = 1'b1;
        end else begin
          accept_o = 1'b1;
          nxt_o    = state_e'({1'b0, sel_i});
        end
      end
      default: begin
        accept_o = 1'b1;
        nxt_o    = state_e'({1'b0, sel_i});
      end
    endcase
  end

endmodule

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
  parameter int RST_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);

  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LOAD_V;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/lpm_pwr_decode.sv
module lpm_pwr_decode
  import lpm_pkg::*;
(
  input  state_e   state_i,
  input  logic     keep_i,
  output pwr_ctl_t ctl_o
);

  always_comb begin
    ctl_o = '{cpu_clk: 1'b1, core_clk: 1'b1, hs_osc: 1'b1, lsi: 1'b1,
              main_reg: 1'b1, lp_reg: 1'b0, core_pwr: 1'b1, sram_on: 1'b1,
              vmon: 1'b1, core_rst: 1'b0};
    unique case (state_i)
      S_RUN: ;
      S_LPRUN: begin
        ctl_o.main_reg = 1'b0;
        ctl_o.lp_reg   = 1'b1;
      end
      S_SLEEP: begin
        ctl_o.cpu_clk = 1'b0;
      end
      S_LPSLEEP: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.main_reg = 1'b0;
        ctl_o.lp_reg   = 1'b1;
      end
      S_STOP0: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.core_clk = 1'b0;
        ctl_o.hs_osc   = 1'b0;
      end
      S_STOP1: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.core_clk = 1'b0;
        ctl_o.hs_osc   = 1'b0;
        ctl_o.main_reg = 1'b0;
        ctl_o.lp_reg   = 1'b1;
      end
      S_STANDBY: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.core_clk = 1'b0;
        ctl_o.hs_osc   = 1'b0;
        ctl_o.main_reg = 1'b0;
        ctl_o.lp_reg   = keep_i;
        ctl_o.core_pwr = 1'b0;
        ctl_o.sram_on  = keep_i;
      end
      S_SHUTDOWN: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.core_clk = 1'b0;
        ctl_o.hs_osc   = 1'b0;
        ctl_o.lsi      = 1'b0;
        ctl_o.main_reg = 1'b0;
        ctl_o.core_pwr = 1'b0;
        ctl_o.sram_on  = 1'b0;
        ctl_o.vmon     = 1'b0;
      end
      S_WRST: begin
        ctl_o.cpu_clk  = 1'b0;
        ctl_o.core_clk = 1'b0;
        ctl_o.core_rst = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int LP_DIV  = 4,
  parameter int WAKE_W  = 4,
  parameter int RST_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_sel_i,
  input  logic              sram_keep_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              wfi_i,
  input  logic [WAKE_W-1:0] wake_i,
  output logic [2:0]        mode_o,
  output logic              err_o,
  output logic              cpu_clk_en_o,
  output logic              core_clk_en_o,
  output logic              hs_osc_en_o,
  output logic              lsi_en_o,
  output logic              main_reg_en_o,
  output logic              lp_reg_en_o,
  output logic              core_pwr_en_o,
  output logic              sram_on_o,
  output logic              vmon_en_o,
  output logic              clk_src_o,
  output logic              core_rst_o
);

  state_e   state_q, state_d;
  logic     ret_lp_q, ret_lp_d;
  logic     keep_q, keep_d;
  clk_src_e src_q, src_d;
  logic     err_q, err_d;
  logic     tmr_start, tmr_done;
  logic     req_acc, req_rej;
  state_e   req_nxt;
  logic     wake_any;
  pwr_ctl_t ctl;

  assign wake_any = |wake_i;

  lpm_req_check #(.DIV_W(DIV_W), .LP_DIV(LP_DIV)) u_req (
    .cur_i    (state_q),
    .sel_i    (mode_e'(mode_sel_i)),
    .div_i    (clk_div_i),
    .accept_o (req_acc),
    .reject_o (req_rej),
    .nxt_o    (req_nxt)
  );

  lpm_rst_timer #(.RST_CYC(RST_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    ret_lp_d  = ret_lp_q;
    keep_d    = keep_q;
    src_d     = src_q;
    err_d     = 1'b0;
    tmr_start = 1'b0;
    unique case (state_q)
      S_RUN, S_LPRUN: begin
        if (wfi_i) begin
          if (req_rej) begin
            err_d = 1'b1;
          end else if (req_acc) begin
            state_d = req_nxt;
            if (req_nxt == S_STOP0 || req_nxt == S_STOP1)
              ret_lp_d = (state_q == S_LPRUN);
            if (req_nxt == S_STANDBY)
              keep_d = sram_keep_i;
          end
        end
      end
      S_SLEEP:   if (wake_any) state_d = S_RUN;
      S_LPSLEEP: if (wake_any) state_d = S_LPRUN;
      S_STOP0, S_STOP1: begin
        if (wake_any) begin
          state_d = ret_lp_q ? S_LPRUN : S_RUN;
          src_d   = CLK_RC_DIV;
        end
      end
      S_STANDBY, S_SHUTDOWN: begin
        if (wake_any) begin
          state_d   = S_WRST;
          tmr_start = 1'b1;
          src_d     = CLK_RC16;
        end
      end
      S_WRST:  if (tmr_done) state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_RUN;
      ret_lp_q <= 1'b0;
      keep_q   <= 1'b0;
      src_q    <= CLK_RC_DIV;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      ret_lp_q <= ret_lp_d;
      keep_q   <= keep_d;
      src_q    <= src_d;
      err_q    <= err_d;
    end
  end

  lpm_pwr_decode u_dec (
    .state_i (state_q),
    .keep_i  (keep_q),
    .ctl_o   (ctl)
  );

  assign mode_o        = (state_q == S_WRST) ? 3'(M_RUN) : state_q[2:0];
  assign err_o         = err_q;
  assign clk_src_o     = src_q;
  assign cpu_clk_en_o  = ctl.cpu_clk;
  assign core_clk_en_o = ctl.core_clk;
  assign hs_osc_en_o   = ctl.hs_osc;
  assign lsi_en_o      = ctl.lsi;
  assign main_reg_en_o = ctl.main_reg;
  assign lp_reg_en_o   = ctl.lp_reg;
  assign core_pwr_en_o = ctl.core_pwr;
  assign sram_on_o     = ctl.sram_on;
  assign vmon_en_o     = ctl.vmon;
  assign core_rst_o    = ctl.core_rst;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
  parameter int DIV_W  = 3,
  parameter int LP_DIV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] clk_div_i,
  input logic [2:0]       mode_o,
  input logic             err_o,
  input logic             cpu_clk_en_o,
  input logic             core_clk_en_o,
  input logic             hs_osc_en_o,
  input logic             lsi_en_o,
  input logic             vmon_en_o,
  input logic             core_pwr_en_o,
  input logic             sram_on_o,
  input logic             clk_src_o,
  input logic             core_rst_o
);

  assert_lprun_slow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && $past(mode_o) == 3'd0) |-> ($past(clk_div_i) >= DIV_W'(LP_DIV)));

  assert_err_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(mode_o) && mode_o <= 3'd1));

  assert_lpsleep_origin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> ($past(mode_o) == 3'd1));

  assert_sleep_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 || mode_o == 3'd3) |-> (!cpu_clk_en_o && core_clk_en_o));

  assert_stop_ctl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 || mode_o == 3'd5) |-> (!core_clk_en_o && !hs_osc_en_o && lsi_en_o && sram_on_o));

  assert_shut_ctl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7) |-> (!lsi_en_o && !vmon_en_o && !core_pwr_en_o && !sram_on_o));

  assert_rst_origin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> ($past(mode_o) >= 3'd6));

  assert_rst_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (mode_o == 3'd0 && clk_src_o && cpu_clk_en_o));

endmodule

bind lpm_seq lpm_seq_chk #(.DIV_W(DIV_W), .LP_DIV(LP_DIV)) u_lpm_seq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_div_i     (clk_div_i),
  .mode_o        (mode_o),
  .err_o         (err_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .core_clk_en_o (core_clk_en_o),
  .hs_osc_en_o   (hs_osc_en_o),
  .lsi_en_o      (lsi_en_o),
  .vmon_en_o     (vmon_en_o),
  .core_pwr_en_o (core_pwr_en_o),
  .sram_on_o     (sram_on_o),
  .clk_src_o     (clk_src_o),
  .core_rst_o    (core_rst_o)
);

// File: tb/lpm_seq_bench.sv
`timescale 1ns/1ps
module lpm_seq_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_sel_i = '0;
  logic       sram_keep_i = 1'b0;
  logic [2:0] clk_div_i = '0;
  logic       wfi_i = 1'b0;
  logic [3:0] wake_i = '0;
  logic [2:0] mode_o;
  logic       err_o, cpu_clk_en_o, core_clk_en_o, hs_osc_en_o, lsi_en_o;
  logic       main_reg_en_o, lp_reg_en_o, core_pwr_en_o, sram_on_o, vmon_en_o;
  logic       clk_src_o, core_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  lpm_seq u_lpm_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_sel_i(mode_sel_i), .sram_keep_i(sram_keep_i),
    .clk_div_i(clk_div_i), .wfi_i(wfi_i), .wake_i(wake_i), .mode_o(mode_o), .err_o(err_o),
    .cpu_clk_en_o(cpu_clk_en_o), .core_clk_en_o(core_clk_en_o), .hs_osc_en_o(hs_osc_en_o),
    .lsi_en_o(lsi_en_o), .main_reg_en_o(main_reg_en_o), .lp_reg_en_o(lp_reg_en_o),
    .core_pwr_en_o(core_pwr_en_o), .sram_on_o(sram_on_o), .vmon_en_o(vmon_en_o),
    .clk_src_o(clk_src_o), .core_rst_o(core_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request or wake cycle; returns at the negedge after the update edge
  task automatic step(input logic w, input logic [2:0] sel, input logic [2:0] div, input logic wk);
    @(negedge clk_i);
    wfi_i = w; mode_sel_i = sel; clk_div_i = div;
    wake_i = wk ? 4'b0100 : 4'b0000;
    @(negedge clk_i);
    wfi_i = 1'b0; wake_i = '0;
  endtask

  task automatic count_rst(input string req);
    int n = 0;
    while (core_rst_o && n < 100) begin
      check({req, " mode during reset"}, 32'(mode_o), 32'd0);
      n++;
      @(negedge clk_i);
    end
    check({req, " reset length"}, 32'(n), 32'd8);
    check({req, " run after reset"}, 32'(mode_o), 32'd0);
    check({req, " rc16 source"}, 32'(clk_src_o), 32'd1);
  endtask

  // {wake, sel, div, exp_mode, exp_err}
  localparam int NV = 15;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {1'b0, 3'd1, 3'd2, 3'd0, 1'b1},  // R2 fast clock, lp run rejected
    {1'b0, 3'd3, 3'd2, 3'd0, 1'b1},  // R3 lp sleep from run
    {1'b0, 3'd1, 3'd4, 3'd1, 1'b0},  // R2 lp run accepted
    {1'b0, 3'd2, 3'd4, 3'd1, 1'b1},  // R3 sleep from lp run
    {1'b0, 3'd3, 3'd4, 3'd3, 1'b0},  // R3 lp sleep from lp run
    {1'b1, 3'd0, 3'd4, 3'd1, 1'b0},  // R5 wake to lp run
    {1'b0, 3'd5, 3'd2, 3'd1, 1'b1},  // R7 stop from lp run, fast clock
    {1'b0, 3'd5, 3'd5, 3'd5, 1'b0},  // R7 stop1 from lp run
    {1'b1, 3'd0, 3'd5, 3'd1, 1'b0},  // R7 wake back to lp run
    {1'b0, 3'd0, 3'd0, 3'd0, 1'b0},  // R2 back to run
    {1'b0, 3'd2, 3'd0, 3'd2, 1'b0},  // R5 sleep
    {1'b0, 3'd4, 3'd0, 3'd2, 1'b0},  // R4 request in sleep ignored
    {1'b1, 3'd0, 3'd0, 3'd0, 1'b0},  // R5 wake to run
    {1'b0, 3'd4, 3'd0, 3'd4, 1'b0},  // R7 stop0 from run
    {1'b1, 3'd0, 3'd0, 3'd0, 1'b0}   // R7 wake to run
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 mode in reset", 32'(mode_o), 32'd0);
    check("R1 enables in reset",
          32'({cpu_clk_en_o, core_clk_en_o, hs_osc_en_o, lsi_en_o, main_reg_en_o,
               lp_reg_en_o, core_pwr_en_o, sram_on_o, vmon_en_o, core_rst_o, err_o, clk_src_o}),
          32'b111110111000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 mode after reset", 32'(mode_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(!VEC[i][10], VEC[i][9:7], VEC[i][6:4], VEC[i][10]);
      check($sformatf("R2/R3 vec%0d mode", i), 32'(mode_o), 32'(VEC[i][3:1]));
      check($sformatf("R2/R3 vec%0d err", i), 32'(err_o), 32'(VEC[i][0]));
    end

    // standby with retention, keep changed after entry
    sram_keep_i = 1'b1;
    step(1'b1, 3'd6, 3'd0, 1'b0);
    check("R8 standby mode", 32'(mode_o), 32'd6);
    sram_keep_i = 1'b0;
    step(1'b0, 3'd0, 3'd0, 1'b0);
    check("R8 kept supply",
          32'({core_pwr_en_o, main_reg_en_o, lp_reg_en_o, sram_on_o}), 32'b0011);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    count_rst("R10 standby");

    // standby without retention
    step(1'b1, 3'd6, 3'd0, 1'b0);
    check("R8 no-retention supply",
          32'({core_pwr_en_o, main_reg_en_o, lp_reg_en_o, sram_on_o}), 32'b0000);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    count_rst("R10 standby2");

    // shutdown
    step(1'b1, 3'd7, 3'd0, 1'b0);
    check("R9 shutdown outputs",
          32'({lsi_en_o, vmon_en_o, sram_on_o, core_pwr_en_o, main_reg_en_o, lp_reg_en_o, hs_osc_en_o}),
          32'd0);
    step(1'b1, 3'd0, 3'd0, 1'b0);
    check("R4 request in shutdown ignored", 32'(mode_o), 32'd7);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    count_rst("R10 shutdown");
    repeat (2) @(negedge clk_i);
    check("R4 no request during reset", 32'(err_o), 32'd0);

    // wake in run ignored
    step(1'b0, 3'd0, 3'd0, 1'b1);
    check("R4 wake in run mode", 32'(mode_o), 32'd0);
    check("R4 wake in run clk src", 32'(clk_src_o), 32'd1);

    // stop0 / stop1 controls, stop wake source
    step(1'b1, 3'd4, 3'd0, 1'b0);
    check("R6 stop0 controls",
          32'({cpu_clk_en_o, core_clk_en_o, hs_osc_en_o, lsi_en_o, main_reg_en_o,
               lp_reg_en_o, sram_on_o, core_pwr_en_o}), 32'b00011011);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    check("R7 stop wake mode", 32'(mode_o), 32'd0);
    check("R7 stop wake divided source", 32'(clk_src_o), 32'd0);
    check("R7 stop wake no reset", 32'(core_rst_o), 32'd0);
    step(1'b1, 3'd5, 3'd0, 1'b0);
    check("R6 stop1 controls",
          32'({cpu_clk_en_o, core_clk_en_o, hs_osc_en_o, lsi_en_o, main_reg_en_o,
               lp_reg_en_o, sram_on_o, core_pwr_en_o}), 32'b00010111);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    check("R7 stop1 wake to run", 32'(mode_o), 32'd0);

    // sleep gating, lp run / lp sleep regulator
    step(1'b1, 3'd2, 3'd0, 1'b0);
    check("R5 sleep gating", 32'({cpu_clk_en_o, core_clk_en_o, main_reg_en_o}), 32'b011);
    step(1'b0, 3'd0, 3'd0, 1'b1);
    step(1'b1, 3'd1, 3'd6, 1'b0);
    step(1'b1, 3'd3, 3'd6, 1'b0);
    check("R5 lp sleep regulator",
          32'({cpu_clk_en_o, core_clk_en_o, main_reg_en_o, lp_reg_en_o}), 32'b0101);

    // reset from a low-power mode
    step(1'b0, 3'd0, 3'd6, 1'b1);
    step(1'b1, 3'd5, 3'd6, 1'b0);
    check("R7 stop1 from lp run", 32'(mode_o), 32'd5);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset mode", 32'(mode_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset clears", 32'({cpu_clk_en_o, lp_reg_en_o, clk_src_o}), 32'b100);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule